// File: doc/BRIEF.md
# Unaligned 64-bit Read Merger for an Eight-Lane Byte-Banked Memory

This block sits between a requester and a memory made of eight byte-wide banks. All eight banks share one word index, so a single memory access returns one 64-bit word. Byte addresses are spread across the banks: byte address A is held in lane A mod 8 of word A div 8. The requester supplies a byte address and receives the eight bytes that start there, packed little-endian so that result byte i is the byte at address A+i.

When the start address lies on an 8-byte boundary, one parallel access is enough. Otherwise the block reads two neighbouring words, one after the other, then selects the upper part of the first word and the lower part of the second and packs them into one result. Each response also reports how many memory accesses it needed and whether the request was misaligned, so the cost of misalignment is visible. Requests use a valid/ready handshake. The memory port has a fixed read latency of one cycle. Responses are held until the consumer accepts them.

Top module: `rdm_unaligned_reader`

## Requirements
- R1: Result byte i (bits 8i+7 down to 8i) equals the memory byte at address A+i, where byte address X is lane X mod 8 of word X div 8 and lane j occupies bits 8j+7 down to 8j of the memory word.
- R2: A request with A mod 8 = 0 causes exactly one memory access, at word index A div 8, and the memory read enable stays low while the block is idle.
- R3: A request with A mod 8 != 0 causes exactly two memory accesses, in consecutive cycles: word index A div 8 first, then the next word.
- R4: For offset k = A mod 8, result bytes 0 to 7-k come from lanes k to 7 of the first word, and result bytes 8-k to 7 come from lanes 0 to k-1 of the second word.
- R5: The second word index is (A div 8 + 1) modulo the memory depth, so a request that crosses the top of memory wraps to word 0.
- R6: The response valid rises two clock edges after the accepting edge for an aligned request, and three edges after it for a misaligned one.
- R7: The request ready is high only when no request is in flight. It goes low at the accepting edge and returns high at the edge where the response is consumed.
- R8: While the response valid is high and the response ready is low, the response valid, data and flags hold steady.
- R9: The response reports an access count of 1 with the misaligned flag low for aligned requests, and a count of 2 with the flag high for misaligned ones.
- R10: A synchronous active-high reset drops the response valid and the memory read enable, abandons any request in flight, and leaves the request ready high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_idx | output | ADDR_W-3 | Word index shared by all banks |
| mem_rd_data | input | 64 | Word returned one cycle after the strobe |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_data | output | 64 | Eight merged bytes, little-endian |
| rsp_misaligned | output | 1 | Start address was not word aligned |
| rsp_accesses | output | 2 | Memory accesses used (1 or 2) |

## Verification
The bench builds the block with ADDR_W = 6, which gives a memory of eight words and 64 byte addresses. That makes it practical to request every start address, so every offset from 0 to 7 is used in every word, including the last word, whose misaligned requests wrap to word 0. The memory model fills each byte from an arithmetic function of its address that gives every byte a distinct value, and the sweep is repeated with a second fill. A wrong lane choice therefore always changes the result. Response back-pressure of varying length and a reset in the middle of a request are also exercised.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_DATA_AL,
    ST_DATA_MIS,
    ST_RESP
  } rdm_state_e;

  localparam int unsigned ACC_W = 2;

endpackage

// File: rtl/rdm_ctrl.sv
module rdm_ctrl
  import rdm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned IDX_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              mem_rd_en,
  output logic [IDX_W-1:0]  mem_rd_idx,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic              rsp_misaligned,
  output logic [ACC_W-1:0]  rsp_accesses,
  output logic [OFF_W-1:0]  off_o,
  output logic              cap_lo,
  output logic              load_rsp,
  output logic              direct_sel
);

  rdm_state_e state_q;
  logic [OFF_W-1:0] off_q;
  logic accept;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign off_o      = off_q;
  assign cap_lo     = (state_q == ST_RD_HI);
  assign load_rsp   = (state_q == ST_DATA_AL) || (state_q == ST_DATA_MIS);
  assign direct_sel = (state_q == ST_DATA_AL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      off_q          <= '0;
      mem_rd_en      <= 1'b0;
      mem_rd_idx     <= '0;
      rsp_valid      <= 1'b0;
      rsp_misaligned <= 1'b0;
      rsp_accesses   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            off_q      <= req_addr[OFF_W-1:0];
            mem_rd_idx <= req_addr[ADDR_W-1:OFF_W];
            mem_rd_en  <= 1'b1;
            state_q    <= ST_RD_LO;
          end
        end
        ST_RD_LO: begin
          if (off_q != '0) begin
            mem_rd_en  <= 1'b1;
            mem_rd_idx <= mem_rd_idx + IDX_W'(1);
            state_q    <= ST_RD_HI;
          end else begin
            mem_rd_en <= 1'b0;
            state_q   <= ST_DATA_AL;
          end
        end
        ST_RD_HI: begin
          mem_rd_en <= 1'b0;
          state_q   <= ST_DATA_MIS;
        end
        ST_DATA_AL: begin
          rsp_valid      <= 1'b1;
          rsp_misaligned <= 1'b0;
          rsp_accesses   <= ACC_W'(1);
          state_q        <= ST_RESP;
        end
        ST_DATA_MIS: begin
          rsp_valid      <= 1'b1;
          rsp_misaligned <= 1'b1;
          rsp_accesses   <= ACC_W'(2);
          state_q        <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: no memory traffic while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !mem_rd_en);

  // R2: an aligned first access is not followed by a second one
  p_aligned_single_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD_LO && off_q == '0) |=> !mem_rd_en);

  // R3/R5: second access targets the following word, wrapping at the top
  p_next_word_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD_LO && off_q != '0) |=>
      (mem_rd_en && mem_rd_idx == $past(mem_rd_idx) + IDX_W'(1)));

  // R7: nothing accepted while a response waits
  p_one_flight_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

endmodule

// File: rtl/rdm_lane_merge.sv
module rdm_lane_merge #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] merged
);

  logic [BYTE_W-1:0] lo_b [LANES];
  logic [BYTE_W-1:0] hi_b [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_unpack
    assign lo_b[j] = lo_word[j*BYTE_W +: BYTE_W];
    assign hi_b[j] = hi_word[j*BYTE_W +: BYTE_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W:0] src;
    assign src = {1'b0, off} + (OFF_W+1)'(i);
    assign merged[i*BYTE_W +: BYTE_W] =
      src[OFF_W] ? hi_b[src[OFF_W-1:0]] : lo_b[src[OFF_W-1:0]];
  end

endmodule

// File: rtl/rdm_datapath.sv
module rdm_datapath #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mem_rd_data,
  input  logic [OFF_W-1:0]  off,
  input  logic              cap_lo,
  input  logic              load_rsp,
  input  logic              direct_sel,
  output logic [WORD_W-1:0] rsp_data
);

  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] lo_sel;
  logic [WORD_W-1:0] merged;

  assign lo_sel = direct_sel ? mem_rd_data : lo_q;

  rdm_lane_merge #(.LANES(LANES), .BYTE_W(BYTE_W)) u_merge (
    .lo_word (lo_sel),
    .hi_word (mem_rd_data),
    .off     (off),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      rsp_data <= '0;
    end else begin
      if (cap_lo)   lo_q     <= mem_rd_data;
      if (load_rsp) rsp_data <= merged;
    end
  end

  // R4: an aligned load takes the returned word as it stands
  p_direct_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (load_rsp && direct_sel && off == '0) |=> (rsp_data == $past(mem_rd_data)));

endmodule

// File: rtl/rdm_unaligned_reader.sv
module rdm_unaligned_reader
  import rdm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned IDX_W  = ADDR_W - OFF_W,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_rd_en,
  output logic [IDX_W-1:0]  mem_rd_idx,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_misaligned,
  output logic [ACC_W-1:0]  rsp_accesses
);

  logic [OFF_W-1:0] off;
  logic cap_lo, load_rsp, direct_sel;

  rdm_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_ready      (req_ready),
    .mem_rd_en      (mem_rd_en),
    .mem_rd_idx     (mem_rd_idx),
    .rsp_ready      (rsp_ready),
    .rsp_valid      (rsp_valid),
    .rsp_misaligned (rsp_misaligned),
    .rsp_accesses   (rsp_accesses),
    .off_o          (off),
    .cap_lo         (cap_lo),
    .load_rsp       (load_rsp),
    .direct_sel     (direct_sel)
  );

  rdm_datapath #(.LANES(LANES), .BYTE_W(BYTE_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .mem_rd_data (mem_rd_data),
    .off         (off),
    .cap_lo      (cap_lo),
    .load_rsp    (load_rsp),
    .direct_sel  (direct_sel),
    .rsp_data    (rsp_data)
  );

  // R8: a stalled response does not change
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_accesses) && $stable(rsp_misaligned)));

  // R9: access count agrees with the misaligned flag
  p_acc_flag_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_accesses == ACC_W'(2)) == rsp_misaligned) &&
                  (rsp_accesses != '0));

endmodule

// File: tb/rdm_unaligned_reader_bench.sv
module rdm_unaligned_reader_bench;

  localparam int ADDR_W = 6;
  localparam int IDX_W  = ADDR_W - 3;
  localparam int NBYTES = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic mem_rd_en;
  logic [IDX_W-1:0] mem_rd_idx;
  logic [63:0] mem_rd_data = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [63:0] rsp_data;
  logic rsp_misaligned;
  logic [1:0] rsp_accesses;

  int n_cmp = 0;
  int n_bad = 0;
  int pat = 0;
  int cyc = 0;
  int nacc = 0;
  int idx_log [4];

  always #5 clk = ~clk;

  rdm_unaligned_reader #(.ADDR_W(ADDR_W)) u_rdm_unaligned_reader (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_misaligned(rsp_misaligned), .rsp_accesses(rsp_accesses)
  );

  function automatic logic [7:0] mbyte(int a);
    return 8'(((a % NBYTES) * 29 + pat * 83 + 11) & 255);
  endfunction

  function automatic logic [63:0] mword(int idx);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[j*8 +: 8] = mbyte(idx * 8 + j);
    return w;
  endfunction

  function automatic logic [63:0] expect_data(int a);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[i*8 +: 8] = mbyte(a + i);
    return w;
  endfunction

  // bank array model: one-cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mword(int'(mem_rd_idx));

  always @(negedge clk) if (mem_rd_en) begin
    if (nacc < 4) idx_log[nacc] = int'(mem_rd_idx);
    nacc++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_req(int a, int hold);
    logic [63:0] exp;
    int n;
    bit mis;
    exp = expect_data(a);
    mis = (a % 8) != 0;
    @(negedge clk);
    nacc = 0;
    chk(req_ready == 1'b1, "R7 ready while idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 20) begin
      chk(req_ready == 1'b0, "R7 busy while in flight", 64'(req_ready), 64'd0);
      @(negedge clk);
      n++;
    end
    chk(n == (mis ? 3 : 2), "R6 response latency", 64'(n), mis ? 64'd3 : 64'd2);
    chk(rsp_data == exp, mis ? "R4 merged bytes" : "R1 aligned bytes", rsp_data, exp);
    chk(nacc == (mis ? 2 : 1), mis ? "R3 two accesses" : "R2 one access",
        64'(nacc), mis ? 64'd2 : 64'd1);
    chk(idx_log[0] == a / 8, "R2 first word index", 64'(idx_log[0]), 64'(a / 8));
    if (mis)
      chk(idx_log[1] == ((a / 8 + 1) % (1 << IDX_W)), "R5 second word index wraps",
          64'(idx_log[1]), 64'((a / 8 + 1) % (1 << IDX_W)));
    chk(rsp_accesses == (mis ? 2'd2 : 2'd1) && rsp_misaligned == mis, "R9 cost flags",
        {rsp_misaligned, rsp_accesses}, {mis, mis ? 2'd2 : 2'd1});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == exp && req_ready == 1'b0, "R8 held under back-pressure",
          rsp_data, exp);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R7 ready after consume", {rsp_valid, req_ready}, 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!rsp_valid && req_ready && !mem_rd_en, "R10 reset state",
        {rsp_valid, req_ready, mem_rd_en}, 64'b010);
    for (int p = 0; p < 2; p++) begin
      pat = p;
      for (int a = 0; a < NBYTES; a++) do_req(a, a % 4);
    end
    // reset while a misaligned request is in flight
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = ADDR_W'(3);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!rsp_valid && req_ready && !mem_rd_en, "R10 reset mid-request",
        {rsp_valid, req_ready, mem_rd_en}, 64'b010);
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_rd_en, "R10 abandoned request stays silent",
        {rsp_valid, mem_rd_en}, 64'b00);
    do_req(61, 1);
    do_req(8, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule